// File: doc/BRIEF.md
# Byte-Serial CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of data that a processor writes into it one register word at a time. Each write carries a 32-bit data word and a byte count. The engine absorbs the valid bytes of that word into the checksum, one byte on each clock cycle, so a message of any length is covered by a series of writes.

While bytes of a written word are still waiting, a busy output is high. Software polls busy and writes again only once it is low. A write that arrives while busy is high is dropped, and a sticky error flag records the event. A synchronous clear input loads a seed into the checksum and clears busy and the error flag.

A mode input selects a 16-bit checksum (generator 0x1021) or a 32-bit checksum (generator 0x04C11DB7). Both are computed most-significant bit first within each byte, with no bit reflection and no final inversion.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, crc_out is 0, busy is 0 and err is 0.
- R2: While clr is high at a clock edge, the checksum is loaded with seed when mode32 is 1, or with {16'h0, seed[15:0]} when mode32 is 0. Any pending bytes are dropped, and busy and err both go to 0 after that edge. clr takes priority over wr_en.
- R3: A write accepted at a clock edge raises busy after that edge. busy then stays high for exactly as many cycles as the write has valid bytes, and one byte is folded in per cycle.
- R4: Within a word, bytes are consumed least-significant first: wr_data[7:0] first, then wr_data[15:8], and so on. In 32-bit mode the update uses generator 0x04C11DB7, MSB first, with no reflection and no output XOR. With seed 0xFFFFFFFF, the nine ASCII bytes "123456789" give 0x0376E6E7.
- R5: In 16-bit mode the update uses generator 0x1021 on crc_out[15:0] and keeps crc_out[31:16] at 0. With seed 0xFFFF, "123456789" gives 0x29B1.
- R6: The checksum accumulates across successive writes until clr is asserted.
- R7: A write with wr_en high while busy is high (and clr low) is ignored: the final checksum is unchanged by it. It also sets err, which stays high until clr.
- R8: The wr_cnt encoding is 2'b00 for one valid byte, 2'b01 for two bytes, and 2'b10 or 2'b11 for four bytes.
- R9: crc_out holds still while busy is low and no write or clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear that loads the seed |
| mode32 | input | 1 | 1 selects the 32-bit checksum, 0 selects the 16-bit checksum |
| seed | input | 32 | Value loaded on clear |
| wr_en | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word, least-significant byte consumed first |
| wr_cnt | input | 2 | Valid byte count code |
| crc_out | output | 32 | Running checksum |
| busy | output | 1 | High while written bytes are still being absorbed |
| err | output | 1 | Sticky flag for a write that arrived while busy |

## Verification
The bench builds the engine with its default generators, 0x04C11DB7 and 0x1021, so the published check values for "123456789" can be compared against in both modes. Those defaults also let a bench reference model, working a byte at a time, track long random sequences of mixed byte counts, random seeds, mode changes and writes made while busy. Using both widths exercises the upper-half zeroing in 16-bit mode and the full 32-bit feedback path.

// File: rtl/crc_byte_engine.sv
`timescale 1ns/1ps
module crc_byte_engine #(
  parameter logic [31:0] POLY32 = 32'h04C11DB7,
  parameter logic [15:0] POLY16 = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        mode32,
  input  logic [31:0] seed,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [1:0]  wr_cnt,
  output logic [31:0] crc_out,
  output logic        busy,
  output logic        err
);

  logic [31:0] crc_q;
  logic [31:0] sh_q;
  logic [2:0]  left_q;
  logic        err_q;
  logic        accept;
  logic [2:0]  nbytes;

  function automatic logic [31:0] fold_byte(logic [31:0] c, logic [7:0] d, logic m);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (m) begin
        fb = r[31] ^ d[i];
        r  = {r[30:0], 1'b0} ^ (fb ? POLY32 : 32'h0);
      end else begin
        fb = r[15] ^ d[i];
        r  = {16'h0, {r[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0)};
      end
    end
    return r;
  endfunction

  assign busy    = (left_q != 3'd0);
  assign err     = err_q;
  assign crc_out = crc_q;
  assign accept  = wr_en && !busy && !clr;
  assign nbytes  = (wr_cnt == 2'b00) ? 3'd1 : (wr_cnt == 2'b01) ? 3'd2 : 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= 32'h0;
      sh_q   <= 32'h0;
      left_q <= 3'd0;
      err_q  <= 1'b0;
    end else if (clr) begin
      crc_q  <= mode32 ? seed : {16'h0, seed[15:0]};
      sh_q   <= 32'h0;
      left_q <= 3'd0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && busy) err_q <= 1'b1;
      if (accept) begin
        sh_q   <= wr_data;
        left_q <= nbytes;
      end else if (busy) begin
        crc_q  <= fold_byte(crc_q, sh_q[7:0], mode32);
        sh_q   <= {8'h0, sh_q[31:8]};
        left_q <= left_q - 3'd1;
      end
    end
  end

endmodule

// File: rtl/crc_byte_engine_chk.sv
`timescale 1ns/1ps
module crc_byte_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        mode32,
  input logic [31:0] seed,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [1:0]  wr_cnt,
  input logic [31:0] crc_out,
  input logic        busy,
  input logic        err
);

  logic [3:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 4'd0;
    else        run <= busy ? ((run == 4'd15) ? run : run + 4'd1) : 4'd0;
  end

  a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 4'd4);

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !clr) |=> busy);

  a_r2_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !err &&
             crc_out == ($past(mode32) ? $past(seed) : {16'h0, $past(seed[15:0])})));

  a_r7_err_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !clr) |=> err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && !clr) |=> $stable(crc_out));

endmodule

bind crc_byte_engine crc_byte_engine_chk u_chk (.*);

// File: tb/test_crc_byte_engine.sv
`timescale 1ns/1ps
module test_crc_byte_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        mode32 = 1'b1;
  logic [31:0] seed = 32'h0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic [1:0]  wr_cnt = 2'b00;
  logic [31:0] crc_out;
  logic        busy;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] ref_crc = 32'h0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  crc_byte_engine i_crc_byte_engine (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] d, logic m);
    logic [31:0] r;
    if (m) begin
      r = c ^ {d, 24'h0};
      for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end else begin
      r = {16'h0, c[15:0] ^ {d, 8'h0}};
      for (int k = 0; k < 8; k++) r = r[15] ? ({16'h0, r[14:0], 1'b0} ^ 32'h1021) : {16'h0, r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic int cnt_bytes(logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  task automatic do_clear(input logic m, input logic [31:0] s);
    mode32 = m; seed = s; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    ref_crc = m ? s : {16'h0, s[15:0]};
    check(crc_out == ref_crc, "R2 seed load", crc_out, ref_crc);
    check(!busy && !err, "R2 flags cleared", {30'h0, busy, err}, 32'h0);
  endtask

  task automatic do_write(input logic [31:0] d, input logic [1:0] c, input bit poke);
    int n;
    wr_data = d; wr_cnt = c; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    n = 0;
    while (busy && n < 10) begin
      if (poke && n == 0) begin
        wr_en = 1'b1; wr_data = ~d; wr_cnt = 2'b10;
      end else wr_en = 1'b0;
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int b = 0; b < cnt_bytes(c); b++) ref_crc = ref_byte(ref_crc, d[8*b +: 8], mode32);
    check(n == cnt_bytes(c), "R3 R8 busy cycles", n, cnt_bytes(c));
    check(crc_out == ref_crc, "R4 R6 checksum", crc_out, ref_crc);
    if (poke) check(err == 1'b1, "R7 err on busy write", {31'h0, err}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(crc_out == 32'h0 && !busy && !err, "R1 reset state", crc_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_clear(1'b1, 32'hFFFFFFFF);
    do_write(32'h34333231, 2'b10, 1'b0);
    do_write(32'h38373635, 2'b11, 1'b0);
    do_write(32'hAAAAAA39, 2'b00, 1'b0);
    check(crc_out == 32'h0376E6E7, "R4 32-bit check value", crc_out, 32'h0376E6E7);

    do_clear(1'b0, 32'h1234FFFF);
    do_write(32'h00003231, 2'b01, 1'b0);
    do_write(32'h36353433, 2'b10, 1'b0);
    do_write(32'h55553837, 2'b01, 1'b0);
    do_write(32'h77777739, 2'b00, 1'b0);
    check(crc_out == 32'h000029B1, "R5 16-bit check value", crc_out, 32'h29B1);

    do_write(32'hDEADBEEF, 2'b10, 1'b1);
    repeat (3) @(negedge clk);
    check(err == 1'b1, "R7 err sticky", {31'h0, err}, 32'h1);
    check(crc_out == ref_crc, "R9 idle hold", crc_out, ref_crc);

    wr_data = 32'hCAFEF00D; wr_cnt = 2'b10; wr_en = 1'b1; clr = 1'b1; mode32 = 1'b1; seed = 32'h0BADF00D;
    @(negedge clk);
    wr_en = 1'b0; clr = 1'b0;
    ref_crc = 32'h0BADF00D;
    check(!busy && crc_out == ref_crc, "R2 clr beats write", crc_out, ref_crc);

    for (int it = 0; it < 300; it++) begin
      logic [31:0] rv;
      rv = $urandom();
      if (rv[3:0] == 4'h0) do_clear(rv[4], $urandom());
      do_write($urandom(), rv[6:5], rv[9:7] == 3'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule